// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is an eight-pin general-purpose I/O port that sits on a microcontroller's I/O register bus. It holds two registers: an output latch and a direction register. A third address gives a read-only view of the pin levels, which pass through a two-stage synchronizer. Each pin drives three signals to its pad: output enable, output value and pull-up enable.

Software can write either register as a whole byte. It can also set or clear a single bit, so one pin changes and the other seven keep their values. When a pin is an input, its latch bit turns on that pin's pull-up. A global pull-up-disable input overrides this. A power-down input disconnects the digital input path. While the reset input is low, the pad outputs are forced to the tri-state condition at once, with no clock edge needed.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the latch and direction registers both read 0x00, and the output enable, output value and pull-up outputs are all 0.
- R2: A byte write (`bus_wr`) stores `bus_wdata` in the latch at 0x1B and in the direction register at 0x1A. The aliases 0x3B and 0x3A reach the same registers, because address bit 5 is ignored. A read (`bus_rd`) of either address returns the stored value in the same cycle.
- R3: The pin view at 0x19 (alias 0x39) is read-only. A write to it leaves both the latch and the direction register unchanged.
- R4: A `bit_set` or `bit_clr` strobe addressed to the latch or the direction register sets or clears bit `bit_idx` on the next clock edge and leaves the other bits unchanged. If strobes coincide, the priority is byte write, then clear, then set.
- R5: `pad_oe` equals the direction register. `pad_out` carries the latch bit for each pin whose direction bit is 1, and is 0 for the other pins.
- R6: `pad_pu` for a pin is 1 only when its direction bit is 0, its latch bit is 1 and `pud` is 0.
- R7: While `rst_n` is low, `pad_oe` and `pad_pu` are all 0 immediately, with no clock edge.
- R8: A read of the pin view returns the level that `pin_in` had two clock edges earlier.
- R9: While `pwr_down` is 1, the pin view reads 0x00 and the synchronizer takes in zeros. After `pwr_down` returns to 0, the live pin level appears after two clock edges.
- R10: `bus_rdata` is 0x00 when `bus_rd` is 0 or when the address maps to none of the three locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | I/O register address |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 8 | Byte write data |
| bit_set | input | 1 | Single-bit set strobe |
| bit_clr | input | 1 | Single-bit clear strobe |
| bit_idx | input | 3 | Bit index for set/clear |
| bus_rdata | output | 8 | Combinational read data |
| pud | input | 1 | Global pull-up disable |
| pwr_down | input | 1 | Power-down, gates the input path |
| pin_in | input | 8 | Pin levels from the pads |
| pad_oe | output | 8 | Output enable per pin |
| pad_out | output | 8 | Output value per pin |
| pad_pu | output | 8 | Pull-up enable per pin |

## Verification
The register path is tried at both the primary and the alias addresses. It is also tried with byte values whose bits differ between adjacent pins, so a dropped, swapped or misdecoded bit shows up. Single-bit strobes are aimed at the lowest and highest indexes and at both registers. Coinciding strobes separate the three priority levels. The pad outputs are checked on a mix of input and output pins, with the pull-up disable both on and off; this tells the latch-as-pull-up role apart from the latch-as-drive role. The pin view is read on the exact cycles around its two-edge latency, both in normal operation and when leaving power-down, so a missing or extra synchronizer stage is exposed.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PORT_W = 8;
  localparam int IDX_W  = $clog2(PORT_W);
  localparam int ADDR_W = 6;
  localparam int OFS_W  = 5;

  localparam logic [OFS_W-1:0] OFS_LAT = 5'h1B;
  localparam logic [OFS_W-1:0] OFS_DIR = 5'h1A;
  localparam logic [OFS_W-1:0] OFS_PIN = 5'h19;

  typedef logic [PORT_W-1:0] port_t;

  // Single-bit update: clear beats set.
  function automatic port_t bit_update(port_t cur, logic [IDX_W-1:0] idx,
                                       logic set, logic clr);
    port_t nxt;
    nxt = cur;
    if (clr)      nxt[idx] = 1'b0;
    else if (set) nxt[idx] = 1'b1;
    return nxt;
  endfunction

  function automatic port_t pull_up_calc(port_t dir, port_t lat, logic pud);
    return ~dir & lat & {PORT_W{~pud}};
  endfunction

  function automatic port_t drive_calc(port_t dir, port_t lat);
    return dir & lat;
  endfunction
endpackage

// File: rtl/gpio_bit_reg.sv
module gpio_bit_reg
  import gpio_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  port_t            wdata,
  input  logic             set,
  input  logic             clr,
  input  logic [IDX_W-1:0] idx,
  output port_t            q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
    else         q <= bit_update(q, idx, set, clr);
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_port_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pwr_down,
  input  port_t pin_in,
  output port_t pin_view
);
  port_t stg [STAGES];
  port_t gated_in;

  assign gated_in = pin_in & {PORT_W{~pwr_down}};

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[s] <= '0;
      else if (s == 0) stg[s] <= gated_in;
      else             stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign pin_view = stg[STAGES-1] & {PORT_W{~pwr_down}};
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_port_pkg::*;
(
  input  logic  rst_n,
  input  logic  pud,
  input  port_t lat_q,
  input  port_t dir_q,
  output port_t pad_oe,
  output port_t pad_out,
  output port_t pad_pu
);
  port_t pu_raw;
  port_t out_raw;

  assign pu_raw  = pull_up_calc(dir_q, lat_q, pud);
  assign out_raw = drive_calc(dir_q, lat_q);

  for (genvar b = 0; b < PORT_W; b++) begin : g_pin
    assign pad_oe[b]  = dir_q[b]   & rst_n;
    assign pad_out[b] = out_raw[b] & rst_n;
    assign pad_pu[b]  = pu_raw[b]  & rst_n;
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [PORT_W-1:0]        bus_wdata,
  input  logic                     bit_set,
  input  logic                     bit_clr,
  input  logic [IDX_W-1:0]         bit_idx,
  output logic [PORT_W-1:0]        bus_rdata,
  input  logic                     pud,
  input  logic                     pwr_down,
  input  logic [PORT_W-1:0]        pin_in,
  output logic [PORT_W-1:0]        pad_oe,
  output logic [PORT_W-1:0]        pad_out,
  output logic [PORT_W-1:0]        pad_pu
);
  logic  hit_lat, hit_dir, hit_pin;
  logic  lat_set_ev, pin_ro_wr;
  port_t lat_q, dir_q, pin_view;

  assign hit_lat = bus_addr[OFS_W-1:0] == OFS_LAT;
  assign hit_dir = bus_addr[OFS_W-1:0] == OFS_DIR;
  assign hit_pin = bus_addr[OFS_W-1:0] == OFS_PIN;

  assign lat_set_ev = hit_lat & bit_set & ~bit_clr & ~bus_wr;
  assign pin_ro_wr  = hit_pin & bus_wr;

  gpio_bit_reg u_lat (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr & hit_lat), .wdata(bus_wdata),
    .set(bit_set & hit_lat), .clr(bit_clr & hit_lat), .idx(bit_idx), .q(lat_q)
  );

  gpio_bit_reg u_dir (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr & hit_dir), .wdata(bus_wdata),
    .set(bit_set & hit_dir), .clr(bit_clr & hit_dir), .idx(bit_idx), .q(dir_q)
  );

  gpio_in_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
    .pin_in(pin_in), .pin_view(pin_view)
  );

  gpio_pad_drive u_pad (
    .rst_n(rst_n), .pud(pud), .lat_q(lat_q), .dir_q(dir_q),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_lat)      bus_rdata = lat_q;
      else if (hit_dir) bus_rdata = dir_q;
      else if (hit_pin) bus_rdata = pin_view;
    end
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pud,
  input  logic             pwr_down,
  input  port_t            pin_in,
  input  port_t            pad_oe,
  input  port_t            pad_pu,
  input  port_t            lat_q,
  input  port_t            dir_q,
  input  port_t            pin_view,
  input  logic             lat_set_ev,
  input  logic             pin_ro_wr,
  input  logic [IDX_W-1:0] bit_idx
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  always_comb begin
    if (!rst_n) begin
      p_tri_r7: assert (pad_oe == '0 && pad_pu == '0) else $error("tri-state");
    end
  end

  p_oe_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe == dir_q);

  p_pu_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu != '0) |-> (((pad_pu & pad_oe) == '0) && !pud));

  p_bit_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lat_set_ev |=> lat_q[$past(bit_idx)]);

  p_ro_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ro_wr |=> ($stable(lat_q) && $stable(dir_q)));

  p_pd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> pin_view == '0);

  p_sync_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3 && !pwr_down && !$past(pwr_down) && !$past(pwr_down, 2))
      |-> pin_view == $past(pin_in, 2));
endmodule

bind gpio_port_ctrl gpio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pud(pud), .pwr_down(pwr_down), .pin_in(pin_in),
  .pad_oe(pad_oe), .pad_pu(pad_pu), .lat_q(lat_q), .dir_q(dir_q),
  .pin_view(pin_view), .lat_set_ev(lat_set_ev), .pin_ro_wr(pin_ro_wr),
  .bit_idx(bit_idx)
);

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 0, bus_rd = 0, bit_set = 0, bit_clr = 0;
  logic [7:0] bus_wdata = '0;
  logic [2:0] bit_idx = '0;
  logic [7:0] bus_rdata;
  logic       pud = 0, pwr_down = 0;
  logic [7:0] pin_in = '0;
  logic [7:0] pad_oe, pad_out, pad_pu;

  int total = 0;
  int bad = 0;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  gpio_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bit_set(bit_set),
    .bit_clr(bit_clr), .bit_idx(bit_idx), .bus_rdata(bus_rdata), .pud(pud),
    .pwr_down(pwr_down), .pin_in(pin_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic judge(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Monitor: compares every queued expectation at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      case (it.kind)
        1:       act = pad_oe;
        2:       act = pad_out;
        3:       act = pad_pu;
        default: act = bus_rdata;
      endcase
      judge(it.req, act, it.exp);
    end
  end

  // Driver tasks: each starts and ends 1 ns after a rising edge.
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    step();
    bus_wr = 0;
  endtask

  task automatic bop(logic [5:0] a, logic [2:0] i, logic s, logic c);
    bus_addr = a; bit_idx = i; bit_set = s; bit_clr = c;
    step();
    bit_set = 0; bit_clr = 0;
  endtask

  task automatic rd(logic [5:0] a, logic [7:0] exp, string req);
    bus_addr = a; bus_rd = 1;
    sb.push_back('{0, exp, req});
    step();
    bus_rd = 0;
  endtask

  task automatic pads(logic [7:0] oe, logic [7:0] o, logic [7:0] pu, string req);
    sb.push_back('{1, oe, req});
    sb.push_back('{2, o, req});
    sb.push_back('{3, pu, req});
    step();
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();

    // R1 reset state
    rd(6'h1B, 8'h00, "R1 latch");
    rd(6'h1A, 8'h00, "R1 dir");
    pads(8'h00, 8'h00, 8'h00, "R1 pads");

    // R2 byte writes, primary and alias
    wr(6'h1B, 8'hA5);
    rd(6'h1B, 8'hA5, "R2 latch");
    wr(6'h3A, 8'h0F);
    rd(6'h1A, 8'h0F, "R2 dir alias write");
    rd(6'h3B, 8'hA5, "R2 latch alias read");

    // R5 / R6 pad outputs
    pads(8'h0F, 8'h05, 8'hA0, "R5 R6 mixed pins");
    pud = 1;
    pads(8'h0F, 8'h05, 8'h00, "R6 pud set");
    pud = 0;

    // R3 pin view is read-only
    wr(6'h19, 8'hFF);
    rd(6'h1B, 8'hA5, "R3 latch kept");
    rd(6'h1A, 8'h0F, "R3 dir kept");
    wr(6'h39, 8'h00);
    rd(6'h1B, 8'hA5, "R3 latch kept alias");
    rd(6'h1A, 8'h0F, "R3 dir kept alias");

    // R4 single-bit access and priority
    bop(6'h1B, 3'd1, 1, 0);
    rd(6'h1B, 8'hA7, "R4 set bit1");
    bop(6'h1B, 3'd7, 0, 1);
    rd(6'h1B, 8'h27, "R4 clear bit7");
    bop(6'h3A, 3'd7, 1, 0);
    rd(6'h1A, 8'h8F, "R4 dir set bit7");
    bop(6'h1A, 3'd0, 1, 1);
    rd(6'h1A, 8'h8E, "R4 clear beats set");
    bus_wdata = 8'h3C; bus_wr = 1;
    bop(6'h1B, 3'd0, 1, 0);
    bus_wr = 0;
    rd(6'h1B, 8'h3C, "R4 write beats set");
    pads(8'h8E, 8'h0C, 8'h30, "R5 R6 after bit ops");

    // R8 two-edge latency
    pin_in = 8'h5A;
    rd(6'h19, 8'h00, "R8 edge0");
    rd(6'h19, 8'h00, "R8 edge1");
    rd(6'h19, 8'h5A, "R8 edge2");
    pin_in = 8'h81;
    step(); step();
    rd(6'h39, 8'h81, "R8 alias");

    // R9 power-down gating
    pwr_down = 1;
    rd(6'h19, 8'h00, "R9 gated");
    pin_in = 8'hC3;
    step();
    rd(6'h19, 8'h00, "R9 still gated");
    pwr_down = 0;
    rd(6'h19, 8'h00, "R9 release edge0");
    rd(6'h19, 8'h00, "R9 release edge1");
    rd(6'h19, 8'hC3, "R9 release edge2");

    // R10 idle and unmapped reads
    rd(6'h10, 8'h00, "R10 unmapped");
    bus_addr = 6'h1B;
    sb.push_back('{0, 8'h00, "R10 rd low"});
    step();

    // R7 asynchronous tri-state
    wr(6'h1A, 8'hF0);
    wr(6'h1B, 8'h0F);
    rst_n = 0;
    #2;
    judge("R7 oe", pad_oe, 8'h00);
    judge("R7 pu", pad_pu, 8'h00);
    step();
    rst_n = 1;
    step();
    rd(6'h1B, 8'h00, "R1 latch after reset");
    rd(6'h1A, 8'h00, "R1 dir after reset");

    step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule